// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register with two ways to change its contents. It can capture a whole byte at once from eight parallel inputs. It can also move its contents one place toward the last stage while a serial input fills the first stage. The last stage drives a true serial output and an inverted copy of it. Typical uses are turning a parallel word into a bit stream, or chaining several registers together through their serial pins.

Everything runs on one fast system clock. The pins behave as slow asynchronous signals: the active-low load pin, the two shift-clock pins, the serial input and the parallel bus all pass through two-flop synchronizers. The two clock pins are ORed together, and a rising edge of that OR is found by comparing the synchronized value with its value one cycle earlier. Either clock pin can therefore act as an active-high inhibit. Load is level-sensitive and has priority over shifting.

Top module: `par_to_ser_shifter`

## Requirements
- R1: While `loadN` is 0, stage k takes `parIn[k]` for every k, whatever the clock pins do. `serOut` then shows `parIn[7]`.
- R2: While `loadN` stays 0, the stages keep following changes on `parIn`.
- R3: Each rising edge of (`clkA` OR `clkB`) with `loadN` at 1 causes one shift. `serialIn` enters stage 0, stage k takes the old stage k-1, and stage 7 drives `serOut`.
- R4: The two clock pins are interchangeable. An edge made with either pin produces the same shift.
- R5: While either clock pin is held at 1, toggling the other pin causes no shift.
- R6: When one clock pin rises while the other is 0, exactly one shift occurs. A falling edge of the OR causes no shift.
- R7: With `loadN` at 1 and no rising edge of the OR, all stages keep their values.
- R8: On the system cycle where the synchronized load returns to 1, a clock edge detected in that same cycle is ignored. The register keeps the value it loaded.
- R9: `serOutN` is always the inverse of `serOut`.
- R10: A synchronous active-high `rst` clears every stage. This gives `serOut` = 0 and `serOutN` = 1.
- R11: A pin change driven before system edge n shows at the outputs after edge n+2. That is two synchronizer flops plus the stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Parallel load, active low, level-sensitive |
| clkA | input | 1 | Shift clock pin A (ORed with B) |
| clkB | input | 1 | Shift clock pin B (ORed with A) |
| serialIn | input | 1 | Serial data into stage 0 |
| parIn | input | 8 | Parallel data, bit k into stage k |
| serOut | output | 1 | Last stage, true form |
| serOutN | output | 1 | Last stage, inverted |

## Verification
The assertions check three properties on every cycle:
- A load strobe copies the synchronized parallel word.
- A shift strobe moves every stage by one place, and no strobe leaves the register unchanged.
- The control never issues a shift while load is active, in the recovery cycle, or when the OR was already high on the previous cycle.

Only the bench scenarios can show the pin-level behaviours. These are:
- exactly one shift on a rising inhibit while the other clock is low;
- stages following a changing bus during a long load;
- the three-edge latency;
- bit order when the whole register is shifted out against a reference model.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } pts_strobe_t;
endpackage

// File: rtl/pts_sync.sv
module pts_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loadN,
  input  logic        clkA,
  input  logic        clkB,
  output pts_strobe_t strb
);
  logic [2:0] pinsS;
  logic loadS, clkAS, clkBS;
  logic orNow, orPrev, loadPrev;
  logic risingEdge, recovering;

  pts_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) syncCtrl_i (
    .clk(clk), .rst(rst), .din({loadN, clkA, clkB}), .dout(pinsS)
  );

  assign loadS = pinsS[2];
  assign clkAS = pinsS[1];
  assign clkBS = pinsS[0];
  assign orNow = clkAS | clkBS;

  always_ff @(posedge clk) begin
    if (rst) begin
      orPrev   <= 1'b0;
      loadPrev <= 1'b1;
    end else begin
      orPrev   <= orNow;
      loadPrev <= loadS;
    end
  end

  assign risingEdge  = orNow & ~orPrev;
  assign recovering  = loadS & ~loadPrev;
  assign strb.load   = ~loadS;
  assign strb.shift  = loadS & ~recovering & risingEdge;

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !loadS |-> !strb.shift); // R1
  AST_RECOVERY_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $rose(loadS) |-> !strb.shift); // R8
  AST_HIGH_OR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ($past(clkAS) || $past(clkBS)) |-> !strb.shift); // R5
endmodule

// File: rtl/pts_datapath.sv
module pts_datapath
  import pts_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  pts_strobe_t      strb,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             lastBit
);
  localparam int TOP = WIDTH - 1;
  logic [WIDTH:0]   dataS;
  logic [WIDTH-1:0] parS;
  logic             serS;
  logic [WIDTH-1:0] stage;

  pts_sync #(.W(WIDTH+1), .STAGES(SYNC_STAGES), .RST_VAL('0)) syncData_i (
    .clk(clk), .rst(rst), .din({serialIn, parIn}), .dout(dataS)
  );

  assign serS = dataS[WIDTH];
  assign parS = dataS[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (rst)             stage <= '0;
    else if (strb.load)  stage <= parS;
    else if (strb.shift) stage <= {stage[TOP-1:0], serS};
  end

  assign lastBit = stage[TOP];

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> stage == $past(parS)); // R1
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !strb.load) |=>
      (stage[TOP:1] == $past(stage[TOP-1:0]) && stage[0] == $past(serS))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strb.shift && !strb.load) |=> $stable(stage)); // R7
endmodule

// File: rtl/par_to_ser_shifter.sv
module par_to_ser_shifter
  import pts_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic             clkA,
  input  logic             clkB,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN
);
  pts_strobe_t strb;
  logic lastBit;

  pts_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .loadN(loadN), .clkA(clkA), .clkB(clkB), .strb(strb)
  );

  pts_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .serialIn(serialIn),
    .parIn(parIn), .lastBit(lastBit)
  );

  assign serOut  = lastBit;
  assign serOutN = ~lastBit;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (serOut == 1'b0 && serOutN == 1'b1)); // R10
endmodule

// File: tb/par_to_ser_shifter_tb.sv
`timescale 1ns/1ps
module par_to_ser_shifter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadN = 1'b1, clkA = 1'b0, clkB = 1'b0, serialIn = 1'b0;
  logic [7:0] parIn = '0;
  logic serOut, serOutN;
  logic [7:0] refq = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  par_to_ser_shifter dut_i (
    .clk(clk), .rst(rst), .loadN(loadN), .clkA(clkA), .clkB(clkB),
    .serialIn(serialIn), .parIn(parIn), .serOut(serOut), .serOutN(serOutN)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkOut(input string tag);
    chk(tag, serOut, refq[7]);
    chk({tag, " R9"}, serOutN, ~refq[7]);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doShift(input logic bitIn, input bit useB);
    serialIn = bitIn;
    if (useB) clkB = 1'b1; else clkA = 1'b1;
    settle();
    refq = {refq[6:0], bitIn};
    chkOut(useB ? "R3 R4 shiftB" : "R3 R4 shiftA");
    if (useB) clkB = 1'b0; else clkA = 1'b0;
    settle();
    chkOut("R6 falling edge no shift");
  endtask

  task automatic doLoad(input logic [7:0] v);
    loadN = 1'b0; parIn = v;
    settle();
    refq = v;
    chkOut("R1 load");
    loadN = 1'b1;
    settle();
    chkOut("R7 hold after load");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset out", serOut, 1'b0);
    chk("R10 reset outN", serOutN, 1'b1);

    // R11 latency: load 0x80, visible after the third edge
    loadN = 1'b0; parIn = 8'h80;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 not yet", serOut, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R11 after third edge", serOut, 1'b1);
    refq = 8'h80;

    // R2 following while load stays low, clocks toggling are ignored (R1)
    parIn = 8'h00; settle(); refq = 8'h00; chkOut("R2 follow 00");
    clkA = 1'b1; settle(); chkOut("R1 clock ignored in load");
    clkA = 1'b0; settle();
    parIn = 8'hBF; settle(); refq = 8'hBF; chkOut("R2 follow BF");
    parIn = 8'h7F; settle(); refq = 8'h7F; chkOut("R2 follow 7F");
    loadN = 1'b1; settle(); chkOut("R7 release");
    for (int i = 0; i < 8; i++) doShift(1'b0, 1'b0);

    // R8 recovery: release load together with a clock edge
    loadN = 1'b0; parIn = 8'hA5; settle(); refq = 8'hA5; chkOut("R1 load A5");
    loadN = 1'b1; clkA = 1'b1; settle(); chkOut("R8 edge at release ignored");
    clkA = 1'b0; settle(); chkOut("R8 still loaded");
    for (int i = 0; i < 8; i++) doShift(1'b1, (i % 2) == 1);

    // R5 inhibit, then R6 rising inhibit
    loadN = 1'b0; parIn = 8'h40; clkA = 1'b1; clkB = 1'b1; settle(); refq = 8'h40;
    loadN = 1'b1; settle(); chkOut("R5 setup");
    for (int i = 0; i < 3; i++) begin
      clkA = 1'b0; settle(); chkOut("R5 inhibited low");
      clkA = 1'b1; settle(); chkOut("R5 inhibited high");
    end
    clkA = 1'b0; settle(); chkOut("R5 inhibit held");
    clkB = 1'b0; settle(); chkOut("R6 falling OR no shift");
    serialIn = 1'b0; clkB = 1'b1; settle();
    refq = {refq[6:0], 1'b0};
    chkOut("R6 rising inhibit one shift");
    clkB = 1'b0; settle(); chkOut("R6 after fall");

    // R1 load in the middle of a shift sequence
    doLoad(8'h3C);
    doShift(1'b1, 1'b0);
    doShift(1'b1, 1'b1);
    doLoad(8'hC3);
    for (int i = 0; i < 8; i++) doShift(1'b0, 1'b1);

    // sweep all patterns through the full register
    for (int p = 0; p < 256; p++) begin
      logic [7:0] sv;
      sv = 8'((p * 5 + 3) & 8'hFF);
      doLoad(8'(p));
      for (int i = 0; i < 8; i++) doShift(sv[i], ((p + i) % 2) == 1);
    end

    // R10 reset in the middle of operation
    doLoad(8'hFF);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    refq = 8'h00;
    chkOut("R10 mid reset");
    doShift(1'b0, 1'b0);
    chkOut("R10 stays clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule